// File: doc/BRIEF.md
# SPI NOR Flash Slave Command Engine

This block is the device side of a small serial NOR flash. It watches the four SPI pins (clock, select, data in, hold), assembles the opcode and any address or data bytes after it, and acts on a byte array held inside the block. The supported commands are:

- reading data, status and identification;
- setting and clearing the write-enable latch;
- page program;
- sector, block and chip erase;
- entering and leaving deep power-down.

A program or erase command changes the array as soon as it is accepted. After that, a down-counter keeps the write-in-progress bit high for a fixed number of system clocks. This stands in for the real cell timing.

All four SPI pins are treated as asynchronous. They pass through two flip-flops on the system clock, and clock edges are found from the synchronized copies. The SCK half period must therefore be several system clocks long. The SPI pins are plain level signals and have no handshake. The serial output has a separate enable, which the pad uses to tri-state it.

Address bytes are taken most significant first. Only the low `MEM_AW` bits of the address select a byte. With the defaults the array holds 256 bytes and:

- pages are 16 bytes;
- sectors are 32 bytes;
- blocks are 64 bytes;
- addresses are sent as three bytes.

Top module: `spi_flash_slave`

## Requirements
- R1: Input bits are sampled on SCK rising edges, most significant bit first. Output bits change after SCK falling edges. SCK may idle low (mode 0) or high (mode 3) while select is high.
- R2: Opcode 03h followed by three address bytes returns the array byte at that address, then the byte at each following address. After the top address the read wraps to 0. Raising select at any bit ends the read.
- R3: Opcode 05h returns the status byte repeatedly. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 read 0.
- R4: Opcode 9Fh returns the type byte (default 31h) and then the capacity byte (default 08h), alternating for as long as clocks continue.
- R5: Opcode 06h sets the write-enable latch and 04h clears it. Each takes effect only when select rises after exactly 8 bits.
- R6: Opcode 02h plus three address bytes plus data bytes ANDs each data byte into the array. The column advances and wraps within the 16-byte page. Page bytes that were not addressed keep their values. The write happens only if select rises on a byte boundary.
- R7: If select rises inside a data byte of a page program, nothing is written and the write-enable latch stays 1.
- R8: Sector erase (20h) and block erase (D8h) set every byte of the 32- or 64-byte region that holds the address to FFh. They run only if exactly the opcode plus 24 address bits were sent. Any other count leaves the array and the latch unchanged.
- R9: Chip erase (C7h) and deep power-down (B9h) act only if select rises right after the eighth bit.
- R10: Write-in-progress reads 1 for the whole program or erase interval. During that interval only the status read drives the output, and every other opcode is ignored. The write-enable latch clears when the interval ends.
- R11: In deep power-down the output stays disabled, and every opcode except ABh has no effect. ABh, sent as exactly 8 bits, leaves deep power-down.
- R12: While hold is low, SCK edges are ignored and the output is disabled. If select rises while hold is low, the command in progress is discarded.
- R13: Program and erase commands do nothing while the write-enable latch is 0.
- R14: After reset the latch is 0, write-in-progress is 0, the block is not in deep power-down, the output is disabled, and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low hold (pauses the transfer) |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
The assertions check the following on every cycle:
- the bit and byte counters restart at each select fall;
- a program or erase starts only with the latch set and never while busy;
- write-in-progress lasts past its start, and the latch clears when it ends;
- the latch is frozen in deep power-down;
- a select rise under hold starts nothing.

Only the bench scenarios can show the remaining behaviour. This covers the data on the serial output in both clock modes, address wrap, and page-column wrap. It also covers the AND-only programming, the exact region boundaries of each erase, and the rejection of frames one bit too long or too short.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RDP  = 8'hAB;

  typedef enum logic [1:0] {
    ER_SECTOR = 2'd0,
    ER_BLOCK  = 2'd1,
    ER_CHIP   = 2'd2
  } erase_kind_e;
endpackage

// File: rtl/spi_pin_frontend.sv
module spi_pin_frontend #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             hold_n,
  output logic             selected,
  output logic             hold_ok,
  output logic             sck_fall,
  output logic             frame_start,
  output logic             frame_end,
  output logic [2:0]       bit_pos,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx
);
  // sync vector order: {hold, mosi, cs, sck}
  logic [3:0] sync1, sync2;
  logic       sck_q, cs_q;
  logic [6:0] shreg;
  logic       sck_s, cs_s, mosi_s, sck_rise;

  assign sck_s  = sync2[0];
  assign cs_s   = sync2[1];
  assign mosi_s = sync2[2];
  assign hold_ok = sync2[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 4'b1010;
      sync2 <= 4'b1010;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sync1 <= {hold_n, mosi, cs_n, sck};
      sync2 <= sync1;
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign selected    = !cs_s;
  assign sck_rise    = !cs_s && hold_ok && sck_s && !sck_q;
  assign sck_fall    = !cs_s && hold_ok && !sck_s && sck_q;
  assign frame_start = cs_q && !cs_s;
  assign frame_end   = !cs_q && cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos   <= 3'd0;
      byte_cnt  <= '0;
      byte_done <= 1'b0;
      byte_val  <= 8'h00;
      byte_idx  <= '0;
      shreg     <= 7'd0;
    end else begin
      byte_done <= 1'b0;
      if (frame_start) begin
        bit_pos  <= 3'd0;
        byte_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_s};
        bit_pos <= bit_pos + 3'd1;
        if (bit_pos == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= {shreg, mosi_s};
          byte_idx  <= byte_cnt;
          if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

  // R1
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_pos == 3'd0 && byte_cnt == '0));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int MEM_AW       = 8,
  parameter int PAGE_AW      = 4,
  parameter int SECTOR_AW    = 5,
  parameter int BLOCK_AW     = 6,
  parameter int PROG_CYCLES  = 600,
  parameter int ERASE_CYCLES = 2000,
  localparam int MEM_BYTES   = 1 << MEM_AW,
  localparam int PAGE_BYTES  = 1 << PAGE_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_go,
  input  logic                    erase_go,
  input  erase_kind_e             erase_kind,
  input  logic [MEM_AW-1:0]       op_addr,
  input  logic [PAGE_BYTES*8-1:0] pdata,
  input  logic [PAGE_BYTES-1:0]   pmask,
  input  logic [MEM_AW-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy
);
  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW      = $clog2(LONGEST + 1);

  logic [7:0]    mem [MEM_BYTES];
  logic [CW-1:0] cnt;
  int unsigned   er_shift;

  always_comb begin
    case (erase_kind)
      ER_SECTOR: er_shift = SECTOR_AW;
      ER_BLOCK:  er_shift = BLOCK_AW;
      default:   er_shift = MEM_AW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      if (erase_go) begin
        for (int i = 0; i < MEM_BYTES; i++)
          if ((i >> er_shift) == (int'(op_addr) >> er_shift)) mem[i] <= 8'hFF;
      end
      if (prog_go) begin
        for (int p = 0; p < PAGE_BYTES; p++)
          if (pmask[p])
            mem[{op_addr[MEM_AW-1:PAGE_AW], PAGE_AW'(p)}] <=
              mem[{op_addr[MEM_AW-1:PAGE_AW], PAGE_AW'(p)}] & pdata[p*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (prog_go)        cnt <= CW'(PROG_CYCLES);
    else if (erase_go)       cnt <= CW'(ERASE_CYCLES);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign busy    = (cnt != '0);
  assign rd_data = mem[rd_addr];

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_go || erase_go));
  // R10
  busy_follows_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |=> busy);
  // R10
  busy_lasts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
  import flash_pkg::*;
#(
  parameter int         ADDR_BYTES   = 3,
  parameter int         MEM_AW       = 8,
  parameter int         PAGE_AW      = 4,
  parameter int         SECTOR_AW    = 5,
  parameter int         BLOCK_AW     = 6,
  parameter int         PROG_CYCLES  = 600,
  parameter int         ERASE_CYCLES = 2000,
  parameter logic [7:0] ID_TYPE      = 8'h31,
  parameter logic [7:0] ID_CAP       = 8'h08
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic spi_hold_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int CNT_W      = 8;
  localparam logic [CNT_W-1:0] HDR   = CNT_W'(1 + ADDR_BYTES);
  localparam logic [CNT_W-1:0] ALAST = CNT_W'(ADDR_BYTES);

  logic             selected, hold_ok, sck_fall, frame_start, frame_end, byte_done;
  logic [2:0]       bit_pos;
  logic [CNT_W-1:0] byte_cnt, byte_idx;
  logic [7:0]       byte_val;

  spi_pin_frontend #(.CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .hold_n(spi_hold_n), .selected(selected), .hold_ok(hold_ok), .sck_fall(sck_fall),
    .frame_start(frame_start), .frame_end(frame_end), .bit_pos(bit_pos),
    .byte_cnt(byte_cnt), .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx)
  );

  logic [7:0]              opcode;
  logic [MEM_AW-1:0]       addr_acc, addr_nx, cmd_addr, rd_ptr;
  logic [PAGE_AW-1:0]      col;
  logic [PAGE_BYTES*8-1:0] pbuf;
  logic [PAGE_BYTES-1:0]   pmask;
  logic                    wel, dp, busy, busy_q, tx_on, miso_q, id_sel;
  logic [6:0]              tx_sh;
  logic [7:0]              rd_data, ld_byte, status;
  logic                    ld_ok, commit, single, prog_go, erase_go;
  erase_kind_e             erase_kind;

  assign addr_nx = MEM_AW'({addr_acc, byte_val});
  assign status  = {6'b0, wel, busy};

  // Byte source for the next output byte, chosen at a byte-aligned falling edge
  always_comb begin
    ld_ok   = 1'b0;
    ld_byte = 8'h00;
    if (!dp && byte_cnt != '0) begin
      case (opcode)
        OP_READ: if (!busy && byte_cnt >= HDR) begin ld_ok = 1'b1; ld_byte = rd_data; end
        OP_RDSR: begin ld_ok = 1'b1; ld_byte = status; end
        OP_RDID: if (!busy) begin ld_ok = 1'b1; ld_byte = id_sel ? ID_CAP : ID_TYPE; end
        default: ;
      endcase
    end
  end

  // Frame acceptance: select rose with hold released on a byte boundary
  assign commit = frame_end && hold_ok && (bit_pos == 3'd0);
  assign single = (byte_cnt == CNT_W'(1));

  always_comb begin
    prog_go    = 1'b0;
    erase_go   = 1'b0;
    erase_kind = ER_CHIP;
    if (commit && !dp && !busy && wel) begin
      case (opcode)
        OP_PP: prog_go = (byte_cnt > HDR);
        OP_SE: begin erase_go = (byte_cnt == HDR); erase_kind = ER_SECTOR; end
        OP_BE: begin erase_go = (byte_cnt == HDR); erase_kind = ER_BLOCK; end
        OP_CE: erase_go = single;
        default: ;
      endcase
    end
  end

  flash_array #(
    .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .SECTOR_AW(SECTOR_AW), .BLOCK_AW(BLOCK_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .erase_kind(erase_kind), .op_addr(cmd_addr), .pdata(pbuf), .pmask(pmask),
    .rd_addr(rd_ptr), .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode <= 8'h00; addr_acc <= '0; cmd_addr <= '0; rd_ptr <= '0; col <= '0;
      pbuf <= '0; pmask <= '0; wel <= 1'b0; dp <= 1'b0; busy_q <= 1'b0;
      tx_on <= 1'b0; miso_q <= 1'b0; id_sel <= 1'b0; tx_sh <= 7'd0;
    end else begin
      busy_q <= busy;
      if (frame_start) begin
        tx_on <= 1'b0; pmask <= '0; id_sel <= 1'b0; miso_q <= 1'b0;
      end
      if (byte_done) begin
        if (byte_idx == '0) opcode <= byte_val;
        else if (byte_idx <= ALAST) begin
          addr_acc <= addr_nx;
          if (byte_idx == ALAST) begin
            cmd_addr <= addr_nx;
            rd_ptr   <= addr_nx;
            col      <= addr_nx[PAGE_AW-1:0];
          end
        end else if (opcode == OP_PP) begin
          pbuf[col*8 +: 8] <= byte_val;
          pmask[col]       <= 1'b1;
          col              <= col + 1'b1;
        end
      end
      if (sck_fall) begin
        if (bit_pos == 3'd0) begin
          tx_on <= ld_ok;
          if (ld_ok) begin
            miso_q <= ld_byte[7];
            tx_sh  <= ld_byte[6:0];
            if (opcode == OP_READ) rd_ptr <= rd_ptr + 1'b1;
            if (opcode == OP_RDID) id_sel <= !id_sel;
          end
        end else begin
          miso_q <= tx_sh[6];
          tx_sh  <= {tx_sh[5:0], 1'b0};
        end
      end
      if (commit && single) begin
        if (dp) begin
          if (opcode == OP_RDP) dp <= 1'b0;
        end else if (!busy) begin
          if (opcode == OP_WREN) wel <= 1'b1;
          if (opcode == OP_WRDI) wel <= 1'b0;
          if (opcode == OP_DP)   dp  <= 1'b1;
        end
      end
      if (busy_q && !busy) wel <= 1'b0;
    end
  end

  assign spi_miso    = miso_q;
  assign spi_miso_oe = tx_on && selected && hold_ok;

  // R13
  start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R10
  wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !wel);
  // R11
  dp_freezes_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && $past(dp)) |-> $stable(wel));
  // R12
  hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hold_ok && !busy && !busy_q) |=> (!$rose(busy) && $stable(wel) && $stable(dp)));
endmodule

// File: tb/test_spi_flash_slave.sv
module test_spi_flash_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe;
  logic mode3 = 1'b0;
  logic oe_seen = 1'b0;
  logic done = 1'b0;
  int checks = 0;
  int errors = 0;
  logic [7:0] rbuf [4];
  logic [7:0] s;

  always #5 clk = ~clk;

  spi_flash_slave i_spi_flash_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  // columns: address, program byte, expected read-back
  localparam logic [23:0] PP_VEC [5] = '{24'h10A5A5, 24'h100F05, 24'h113C3C, 24'hFF8181, 24'h007E7E};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sel();
    sck = mode3; tick(HALF);
    cs_n = 1'b0; oe_seen = 1'b0; tick(HALF);
  endtask

  task automatic desel();
    if (!mode3 && sck) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1; tick(2*HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 0; b < n; b++) begin
      sck = 1'b0; mosi = tx[7-b]; tick(HALF);
      rx = {rx[6:0], miso};
      if (miso_oe) oe_seen = 1'b1;
      sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, 8, d); desel();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [7:0] a);
    logic [7:0] d;
    xfer(op, 8, d); xfer(8'h00, 8, d); xfer(8'h00, 8, d); xfer(a, 8, d);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, st); desel();
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    sel(); hdr(8'h03, a);
    for (int k = 0; k < n; k++) xfer(8'h00, 8, rbuf[k]);
    desel();
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(5); rst_n = 1'b1; tick(5);
    // R14 reset state
    chk("R14 oe after reset", {7'd0, miso_oe}, 8'h00);
    rdsr(s); chk("R14 status after reset", s, 8'h00);
    rd(8'h00, 1); chk("R14 array erased", rbuf[0], 8'hFF);

    // R4 / R1 identification in mode 3
    mode3 = 1'b1;
    sel(); xfer(8'h9F, 8, d);
    for (int k = 0; k < 3; k++) xfer(8'h00, 8, rbuf[k]);
    desel();
    chk("R4 id first", rbuf[0], 8'h31);
    chk("R4 id second", rbuf[1], 8'h08);
    chk("R4 id repeat", rbuf[2], 8'h31);
    mode3 = 1'b0;

    // R5 latch set / clear / bit-count rule
    cmd(8'h06); rdsr(s); chk("R5 wren", s, 8'h02);
    chk("R3 status repeat", s, 8'h02);
    cmd(8'h04); rdsr(s); chk("R5 wrdi", s, 8'h00);
    sel(); xfer(8'h06, 8, d); xfer(8'h00, 1, d); desel();
    rdsr(s); chk("R5 wren 9 bits ignored", s, 8'h00);

    // R6 table of single-byte programs
    for (int i = 0; i < 5; i++) begin
      cmd(8'h06);
      sel(); hdr(8'h02, PP_VEC[i][23:16]); xfer(PP_VEC[i][15:8], 8, d); desel();
      wait_ready();
      rdsr(s); chk("R10 wel cleared after program", s, 8'h00);
      rd(PP_VEC[i][23:16], 1); chk("R6 program AND", rbuf[0], PP_VEC[i][7:0]);
    end

    // R6 page column wrap
    cmd(8'h06);
    sel(); hdr(8'h02, 8'h2E); xfer(8'h11, 8, d); xfer(8'h22, 8, d); xfer(8'h33, 8, d); desel();
    wait_ready();
    rd(8'h2E, 3);
    chk("R6 col 2E", rbuf[0], 8'h11);
    chk("R6 col 2F", rbuf[1], 8'h22);
    chk("R6 next page untouched", rbuf[2], 8'hFF);
    rd(8'h20, 2);
    chk("R6 wrapped to 20", rbuf[0], 8'h33);
    chk("R6 unaddressed 21", rbuf[1], 8'hFF);

    // R2 read wrap, R1 mode 3 read
    rd(8'hFF, 2);
    chk("R2 top byte", rbuf[0], 8'h81);
    chk("R2 wrap to zero", rbuf[1], 8'h7E);
    mode3 = 1'b1;
    rd(8'h10, 2);
    chk("R1 mode3 read 10", rbuf[0], 8'h05);
    chk("R1 mode3 read 11", rbuf[1], 8'h3C);
    mode3 = 1'b0;

    // R10 busy behaviour, R8 sector erase
    cmd(8'h06);
    sel(); hdr(8'h20, 8'h10); desel();
    rdsr(s); chk("R10 wip during erase", s, 8'h03);
    rd(8'h20, 1); chk("R10 read ignored while busy", {7'd0, oe_seen}, 8'h00);
    wait_ready();
    rdsr(s); chk("R10 done clears wel", s, 8'h00);
    rd(8'h00, 2);
    chk("R8 sector 00", rbuf[0], 8'hFF);
    chk("R8 sector 01", rbuf[1], 8'hFF);
    rd(8'h10, 2);
    chk("R8 sector 10", rbuf[0], 8'hFF);
    chk("R8 sector 11", rbuf[1], 8'hFF);
    rd(8'h20, 1); chk("R8 outside sector", rbuf[0], 8'h33);

    // R8 wrong bit counts
    cmd(8'h06);
    sel(); hdr(8'h20, 8'h20); xfer(8'h00, 1, d); desel();
    rdsr(s); chk("R8 long erase ignored status", s, 8'h02);
    rd(8'h20, 1); chk("R8 long erase ignored data", rbuf[0], 8'h33);
    sel(); xfer(8'h20, 8, d); xfer(8'h00, 8, d); xfer(8'h20, 8, d); desel();
    rd(8'h20, 1); chk("R8 short erase ignored", rbuf[0], 8'h33);

    // R9 chip erase with a stray bit
    sel(); xfer(8'hC7, 8, d); xfer(8'h00, 1, d); desel();
    rdsr(s); chk("R9 chip erase 9 bits ignored", s, 8'h02);
    rd(8'h20, 1); chk("R9 data kept", rbuf[0], 8'h33);

    // R7 incomplete program byte
    sel(); hdr(8'h02, 8'h40); xfer(8'h00, 8, d); xfer(8'h00, 3, d); desel();
    rdsr(s); chk("R7 wel kept", s, 8'h02);
    rd(8'h40, 1); chk("R7 nothing written", rbuf[0], 8'hFF);

    // R13 erase without latch
    cmd(8'h04);
    sel(); hdr(8'h20, 8'h20); desel();
    rdsr(s); chk("R13 no busy without wel", s, 8'h00);
    rd(8'h20, 1); chk("R13 data kept", rbuf[0], 8'h33);

    // R8 block erase
    cmd(8'h06);
    sel(); hdr(8'hD8, 8'h20); desel();
    wait_ready();
    rd(8'h2E, 1); chk("R8 block erased", rbuf[0], 8'hFF);
    rd(8'h20, 1); chk("R8 block erased 20", rbuf[0], 8'hFF);
    rd(8'hFF, 1); chk("R8 outside block", rbuf[0], 8'h81);

    // R9 / R11 deep power-down
    sel(); xfer(8'hB9, 8, d); xfer(8'h00, 1, d); desel();
    rdsr(s); chk("R9 dp 9 bits ignored", {7'd0, oe_seen}, 8'h01);
    cmd(8'hB9);
    rdsr(s); chk("R11 no output in dp", {7'd0, oe_seen}, 8'h00);
    cmd(8'h06);
    cmd(8'hAB);
    rdsr(s);
    chk("R11 released output", {7'd0, oe_seen}, 8'h01);
    chk("R11 wren ignored in dp", s, 8'h00);

    // R12 select rise under hold discards command
    sel(); xfer(8'h06, 8, d);
    sck = 1'b0; tick(HALF);
    hold_n = 1'b0; tick(HALF);
    cs_n = 1'b1; tick(HALF);
    hold_n = 1'b1; tick(2*HALF);
    rdsr(s); chk("R12 hold abort", s, 8'h00);

    // R12 hold pause mid-byte
    sel(); xfer(8'h06, 4, d);
    sck = 1'b0; tick(HALF);
    hold_n = 1'b0; tick(HALF);
    for (int k = 0; k < 3; k++) begin
      mosi = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    hold_n = 1'b1; tick(HALF);
    xfer(8'h60, 4, d); desel();
    rdsr(s); chk("R12 hold pause resumes", s, 8'h02);

    // R9 chip erase
    cmd(8'hC7);
    rdsr(s); chk("R9 chip erase busy", s, 8'h03);
    wait_ready();
    rd(8'hFF, 1); chk("R9 chip erased FF", rbuf[0], 8'hFF);
    rd(8'h10, 1); chk("R9 chip erased 10", rbuf[0], 8'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule